// File: doc/BRIEF.md
# Serial Frame Boundary Lock Detector

This block takes a recovered serial bit stream, one bit per cycle in which `bit_vld` is high, and finds where each 18-bit frame begins without any training sequence. A frame carries a marker bit of 1, then 16 payload bits, then a marker bit of 0. The boundary is therefore the one bit position where a 0 is followed by a 1 in every frame. The block follows all 18 candidate positions at once. It declares lock only when exactly one position has shown that rising edge for a long, unbroken run of frames.

Once locked, the block stops searching and checks the two marker bits of every frame. For each frame whose markers are correct, it delivers the 16 payload bits as one parallel word. The payload never influences lock. Lock is released only when two frames in a row have bad markers. After that, the search starts again with cleared history.

The output word interface is valid-only and has no ready signal. A serial line cannot be stalled, so the block applies no back-pressure: the consumer must take `word_data` in the single cycle that `word_vld` is high. `word_data` holds its value until the next word arrives or lock is lost. `link_lock` is a plain status level.

Top module: `frame_lock_detector`

## Requirements
- R1: After reset, `link_lock` and `word_vld` are 0 and `word_data` is all zeros.
- R2: A frame is 18 consecutive enabled bits: a head marker (expected 1), payload bits d0 to d15, then a tail marker (expected 0). `word_data[k]` is the k-th payload bit received after the head marker.
- R3: Each candidate position counts the frames in a row in which a 0-to-1 transition lands on it. Lock rises at the enabled cycle that samples the head bit of the frame giving that position its 33rd consecutive rise (LOCK_RUN+1). For a steady 0x00FF payload sent from reset, that is frame index 33, counting from 0.
- R4: A frame in which the candidate position shows no rise resets its count to zero. Lock then needs LOCK_RUN+1 further consecutive rises.
- R5: While more than one position holds a saturated count, lock is never declared. Lock follows once the competing repetitive transition breaks.
- R6: While locked, payload content has no effect on lock. This holds for fixed, random, periodic, sync-like or edge-mimicking payloads.
- R7: While locked, `word_vld` is high for exactly one cycle, directly after the cycle that samples a good tail marker. It is issued only for frames whose head was 1 and tail was 0, and `word_data` then equals that frame's payload.
- R8: A single frame with a bad marker keeps lock and produces no word. A following good frame clears the error history, so isolated bad frames never accumulate.
- R9: A second consecutive bad frame drops lock at the cycle that samples its tail marker. All candidate counts are cleared, so relock needs LOCK_RUN+1 fresh consecutive rises.
- R10: While `link_lock` is 0, `word_vld` is 0 and `word_data` is all zeros.
- R11: A cycle with `bit_vld` low changes neither `link_lock` nor `word_data`, and raises no `word_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Recovered serial bit |
| word_data | output | PAY_W | Payload of the last good frame; zero while unlocked |
| word_vld | output | 1 | One-cycle strobe marking a new `word_data` |
| link_lock | output | 1 | Frame boundary locked |

## Verification
The tail-marker check must resolve in the same cycle as two other events: a word strobe on one path, and loss of lock with clearing of the search counters on the other. A second consecutive bad frame must suppress the strobe, zero the data and clear the search history at that single edge. The bench provokes this by sending a bad-head frame followed by a bad-tail frame. It judges the result by the lock level, the zeroed data and the exact frame on which relock occurs. A second shared cycle comes when the head bit that raises lock also begins the first frame the tracker must deliver. The bench queues that frame's payload at the lock edge and requires it to be the first word out.

// File: rtl/frame_lock_pkg.sv
package frame_lock_pkg;
  localparam int DEF_PAY_W    = 16;
  localparam int DEF_LOCK_RUN = 32;

  typedef enum logic [1:0] {
    SLOT_HEAD = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_TAIL = 2'd2
  } slot_kind_e;
endpackage

// File: rtl/fld_phase_counter.sv
module fld_phase_counter #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  input  logic hit,
  output logic saturated
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_q <= '0;
    end else if (step) begin
      if (!hit)            run_q <= '0;
      else if (run_q != TOP) run_q <= run_q + 1'b1;
    end
  end

  assign saturated = (run_q == TOP);
endmodule

// File: rtl/fld_phase_hunt.sv
module fld_phase_hunt #(
  parameter int FRAME_LEN = 18,
  parameter int LOCK_RUN  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic search_en,
  input  logic clear,
  output logic lock_req
);
  localparam int PW = $clog2(FRAME_LEN);
  localparam logic [PW-1:0] POS_LAST = PW'(FRAME_LEN - 1);

  logic [PW-1:0]        pos_q;
  logic                 prev_q;
  logic                 rise;
  logic [FRAME_LEN-1:0] sat;
  logic                 single_sat;

  // free-running bit position modulo the frame length
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= '0;
      prev_q <= 1'b1;
    end else if (bit_vld) begin
      pos_q  <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      prev_q <= bit_in;
    end
  end

  assign rise = !prev_q && bit_in;

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_phase
    fld_phase_counter #(.LIMIT(LOCK_RUN)) cnt_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clear),
      .step      (bit_vld && search_en && (pos_q == PW'(g))),
      .hit       (rise),
      .saturated (sat[g])
    );
  end

  always_comb begin
    int unsigned n;
    n = 0;
    for (int i = 0; i < FRAME_LEN; i++) n += int'(sat[i]);
    single_sat = (n == 1);
  end

  // a saturated candidate rising once more: every other phase has been
  // revisited since it saturated, so a competing edge would show here
  assign lock_req = search_en && bit_vld && rise && sat[pos_q] && single_sat;
endmodule

// File: rtl/fld_frame_track.sv
module fld_frame_track
  import frame_lock_pkg::*;
#(
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             lock_req,
  output logic             locked,
  output logic             drop,
  output logic [PAY_W-1:0] word_data,
  output logic             word_vld
);
  localparam int FRAME_LEN = PAY_W + 2;
  localparam int SW = $clog2(FRAME_LEN);
  localparam logic [SW-1:0] SLOT_LAST = SW'(FRAME_LEN - 1);

  logic [SW-1:0]    slot_q;
  logic             head_ok_q;
  logic             bad_once_q;
  logic [PAY_W-1:0] pay_q;
  slot_kind_e       kind;
  logic             at_tail;
  logic             tail_good;

  always_comb begin
    if (slot_q == '0)             kind = SLOT_HEAD;
    else if (slot_q == SLOT_LAST) kind = SLOT_TAIL;
    else                          kind = SLOT_DATA;
  end

  assign at_tail   = locked && bit_vld && (kind == SLOT_TAIL);
  assign tail_good = head_ok_q && !bit_in;
  assign drop      = at_tail && !tail_good && bad_once_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      slot_q     <= '0;
      head_ok_q  <= 1'b0;
      bad_once_q <= 1'b0;
      pay_q      <= '0;
      word_data  <= '0;
      word_vld   <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!locked) begin
        if (lock_req) begin
          locked     <= 1'b1;
          slot_q     <= SW'(1);
          head_ok_q  <= 1'b1;
          bad_once_q <= 1'b0;
        end
      end else if (bit_vld) begin
        slot_q <= (kind == SLOT_TAIL) ? '0 : slot_q + 1'b1;
        unique case (kind)
          SLOT_HEAD: head_ok_q <= bit_in;
          SLOT_DATA: begin
            for (int k = 0; k < PAY_W; k++)
              if (slot_q == SW'(k + 1)) pay_q[k] <= bit_in;
          end
          SLOT_TAIL: begin
            if (tail_good) begin
              bad_once_q <= 1'b0;
              word_vld   <= 1'b1;
              word_data  <= pay_q;
            end else if (bad_once_q) begin
              locked     <= 1'b0;
              bad_once_q <= 1'b0;
              word_data  <= '0;
            end else begin
              bad_once_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/frame_lock_detector.sv
module frame_lock_detector
  import frame_lock_pkg::*;
#(
  parameter int PAY_W    = DEF_PAY_W,
  parameter int LOCK_RUN = DEF_LOCK_RUN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_in,
  output logic [PAY_W-1:0] word_data,
  output logic             word_vld,
  output logic             link_lock
);
  localparam int FRAME_LEN = PAY_W + 2;

  logic lock_req;
  logic locked;
  logic drop;

  fld_phase_hunt #(.FRAME_LEN(FRAME_LEN), .LOCK_RUN(LOCK_RUN)) hunt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .search_en (!locked),
    .clear     (drop),
    .lock_req  (lock_req)
  );

  fld_frame_track #(.PAY_W(PAY_W)) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_vld   (bit_vld),
    .bit_in    (bit_in),
    .lock_req  (lock_req),
    .locked    (locked),
    .drop      (drop),
    .word_data (word_data),
    .word_vld  (word_vld)
  );

  assign link_lock = locked;
endmodule

// File: rtl/frame_lock_detector_sva.sv
module frame_lock_detector_sva #(
  parameter int PAY_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_vld,
  input logic             bit_in,
  input logic [PAY_W-1:0] word_data,
  input logic             word_vld,
  input logic             link_lock
);
  assert_vld_only_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> link_lock);

  assert_single_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |=> !word_vld);

  assert_quiet_unlocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_lock |-> (word_data == '0 && !word_vld));

  assert_lock_on_head_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_lock) |-> $past(bit_vld && bit_in));

  assert_drop_on_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_lock) |-> $past(bit_vld));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_vld |=> ($stable(link_lock) && $stable(word_data) && !word_vld));
endmodule

bind frame_lock_detector frame_lock_detector_sva #(.PAY_W(PAY_W)) sva_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_vld   (bit_vld),
  .bit_in    (bit_in),
  .word_data (word_data),
  .word_vld  (word_vld),
  .link_lock (link_lock)
);

// File: tb/frame_lock_detector_tb_top.sv
module frame_lock_detector_tb_top;
  localparam int PAY_W = 16;
  localparam logic [PAY_W-1:0] SYNC_WORD = 16'h00FF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic [PAY_W-1:0] word_data;
  logic word_vld;
  logic link_lock;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit last_lock_h;
  logic [PAY_W-1:0] exp_q[$];

  always #5 clk = ~clk;

  frame_lock_detector #(.PAY_W(PAY_W), .LOCK_RUN(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .word_data(word_data), .word_vld(word_vld), .link_lock(link_lock)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // payload with a forced 0-then-1 pair on d3,d4 (edge-mimicking)
  function automatic logic [PAY_W-1:0] mimic_word(logic [PAY_W-1:0] r);
    return (r & ~16'h0008) | 16'h0010;
  endfunction

  task automatic send_bit(logic b);
    int gap;
    logic l0;
    logic [PAY_W-1:0] d0;
    gap = $urandom_range(0, 2);
    l0 = link_lock;
    repeat (gap) @(negedge clk);
    if (gap > 1) begin
      check(link_lock == l0, "R11", "lock changed on idle cycles", link_lock, l0);
    end
    d0 = word_data;
    bit_vld = 1'b1;
    bit_in = b;
    @(negedge clk);
    bit_vld = 1'b0;
    if (gap > 0 && $urandom_range(0, 7) == 0) begin
      @(negedge clk);
      @(negedge clk);
      check(!word_vld, "R11", "strobe on idle cycle", word_vld, 0);
    end
  endtask

  task automatic send_frame(logic [PAY_W-1:0] pay, logic h, logic t);
    send_bit(h);
    last_lock_h = link_lock;
    if (link_lock && h && !t) exp_q.push_back(pay);
    for (int k = 0; k < PAY_W; k++) send_bit(pay[k]);
    send_bit(t);
  endtask

  // output word monitor (R2, R7)
  always @(negedge clk) begin
    if (rst_n && word_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7", "unexpected word strobe", word_data, 0);
      end else begin
        logic [PAY_W-1:0] e;
        e = exp_q.pop_front();
        check(word_data == e, "R2", "payload mismatch", word_data, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int got_lock;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!link_lock, "R1", "lock after reset", link_lock, 0);
    check(!word_vld, "R1", "strobe after reset", word_vld, 0);
    check(word_data == '0, "R1", "data after reset", word_data, 0);

    // R3: sync payload from reset locks at frame 33
    for (int i = 0; i < 34; i++) begin
      send_frame(SYNC_WORD, 1'b1, 1'b0);
      if (i == 10) begin
        check(word_data == '0 && !word_vld, "R10", "outputs while searching", word_data, 0);
      end
      if (i == 32) check(!last_lock_h, "R3", "lock one frame early", last_lock_h, 0);
      if (i == 33) check(last_lock_h, "R3", "lock at frame 33", last_lock_h, 1);
    end

    // R6: payload variety while locked
    for (int i = 0; i < 24; i++) begin
      logic [PAY_W-1:0] p;
      case (i % 6)
        0: p = 16'h0000;
        1: p = 16'hFFFF;
        2: p = mimic_word(16'($urandom));
        3: p = SYNC_WORD;
        4: p = 16'h5555;
        default: p = 16'($urandom);
      endcase
      send_frame(p, 1'b1, 1'b0);
      check(link_lock, "R6", "lock lost on payload", link_lock, 1);
    end

    // R8: isolated bad frames keep lock
    send_frame(16'($urandom), 1'b1, 1'b1);
    check(link_lock, "R8", "lock after one bad tail", link_lock, 1);
    send_frame(16'hA5C3, 1'b1, 1'b0);
    send_frame(16'($urandom), 1'b0, 1'b0);
    check(link_lock, "R8", "lock after bad head", link_lock, 1);
    send_frame(16'h3C5A, 1'b1, 1'b0);
    send_frame(16'($urandom), 1'b1, 1'b1);
    check(link_lock, "R8", "error history cleared", link_lock, 1);
    send_frame(16'h1234, 1'b1, 1'b0);

    // R9: two consecutive bad frames drop lock, relock needs 33 frames
    send_frame(16'($urandom), 1'b0, 1'b0);
    send_frame(16'($urandom), 1'b1, 1'b1);
    check(!link_lock, "R9", "lock after two bad frames", link_lock, 0);
    check(word_data == '0, "R9", "data zeroed on drop", word_data, 0);
    for (int i = 0; i < 34; i++) begin
      send_frame(16'($urandom), 1'b1, 1'b0);
      if (i == 32) check(!last_lock_h, "R9", "relock too early", last_lock_h, 0);
      if (i == 33) check(last_lock_h, "R9", "relock at frame 33", last_lock_h, 1);
    end

    // R4: a missed rise restarts the count
    send_frame(16'($urandom), 1'b1, 1'b1);
    send_frame(16'($urandom), 1'b1, 1'b1);
    check(!link_lock, "R4", "unlock before miss test", link_lock, 0);
    for (int i = 0; i < 54; i++) begin
      send_frame(SYNC_WORD, (i == 20) ? 1'b0 : 1'b1, 1'b0);
      if (i == 52) check(!last_lock_h, "R4", "lock despite miss", last_lock_h, 0);
      if (i == 53) check(last_lock_h, "R4", "lock 33 frames after miss", last_lock_h, 1);
    end

    // R5: repetitive second edge blocks lock
    send_frame(16'($urandom), 1'b1, 1'b1);
    send_frame(16'($urandom), 1'b1, 1'b1);
    for (int i = 0; i < 80; i++) begin
      send_frame(mimic_word(16'($urandom)), 1'b1, 1'b0);
      if (i % 16 == 15) check(!last_lock_h, "R5", "lock with two edges", last_lock_h, 0);
      if (i == 40) begin
        check(word_data == '0 && !word_vld, "R10", "outputs while blocked", word_data, 0);
      end
    end
    got_lock = 0;
    for (int i = 0; i < 40; i++) begin
      send_frame(16'($urandom), 1'b1, 1'b0);
      if (last_lock_h) got_lock = 1;
    end
    check(got_lock == 1, "R5", "lock after edge pattern breaks", got_lock, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7", "words still owed", exp_q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule